// File: doc/BRIEF.md
# Sequential radix-2 Booth multiplier

This block multiplies a signed two's complement multiplicand of `XW` bits by a signed two's complement multiplier of `YW` bits. It spends one clock per multiplier bit and returns a signed product of `XW+YW` bits. A start pulse captures both operands. From them the block builds one working register and two addend words. The first addend word adds the multiplicand and the second subtracts it. Both words carry the multiplicand in their upper field and zeros below it.

On every busy cycle the block looks at the two lowest bits of the working register. For `01` it adds the plus-word, for `10` it adds the minus-word, and for `00` or `11` it does nothing. The register is then shifted right by one place with its sign bit copied. After `YW` such steps the register, minus its lowest bit, is the product. The block pulses `done` for one cycle and holds the product until the next accepted start.

The upper field is kept one bit wider than the multiplicand. This lets the negation of the most negative multiplicand be represented without wrapping, so that case needs no range restriction.

Top module: `booth_r2_seq_mult`

## Requirements
- R1: After reset, `busy` and `done` are low and `product` is zero.
- R2: A start seen while `busy` is low is accepted, and `busy` is high from the next cycle. The operands present at that edge are captured, and later changes on `mcand` or `mplier` do not change the result.
- R3: One recoding step is done per clock. If start is accepted at edge k, then `done` is high exactly in the cycle between edges k+YW and k+YW+1.
- R4: `done` is high for a single cycle, and `busy` is low whenever `done` is high.
- R5: While `done` is high, `product` equals the signed product of the captured operands. This holds for every operand value, the most negative ones included.
- R6: Once `done` has been shown, `product` stays unchanged until the next accepted start.
- R7: A start seen while `busy` is high is ignored. The run in progress keeps its length and its operands.
- R8: A start seen in the same cycle that `done` is high is accepted. The next run begins back to back.
- R9: Recoding uses the register's two low bits as follows: `01` adds the multiplicand at the top, `10` subtracts it, and `00` or `11` leave the register unchanged before the shift. For example, 3 times -4 in the 5-by-4 configuration gives 9'h1F4 (-12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a multiplication |
| mcand | input | XW | Signed multiplicand |
| mplier | input | YW | Signed multiplier |
| busy | output | 1 | High while recoding steps are in progress |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | XW+YW | Signed product, held until the next start |

## Verification
The end of one run and the start of the next can fall in the same cycle: `done` is high and `start` is high together. The bench provokes this by raising `start` with fresh operands at the very sample where it first sees `done`. It then judges the new run as it would any other. `busy` must be high on the next sample, `done` must come back after exactly YW+1 samples, and the product must match the new operands. The bench also raises `start` in the middle of a run with a different multiplicand. It then checks that neither the run length nor the product moves.

// File: rtl/booth_pkg.sv
// Package: shared types and the recoding decision for the Booth multiplier.
// Assumes: callers pass the two lowest bits of the working register.
package booth_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_PLUS = 2'd1,
        ACT_MINUS = 2'd2
    } booth_act_e;

    // Map the low register bit pair to the step action.
    function automatic booth_act_e pick_action(input logic [1:0] pair);
        booth_act_e act;
        unique case (pair)
            2'b01:   act = ACT_PLUS;
            2'b10:   act = ACT_MINUS;
            default: act = ACT_HOLD;
        endcase
        return act;
    endfunction

endpackage

// File: rtl/booth_operand_prep.sv
// Module: booth_operand_prep
// Builds the initial working word and the two addend words from raw operands.
// The top field is XW+1 bits wide, so negating the most negative multiplicand
// cannot wrap. Purely combinational.
module booth_operand_prep #(
    parameter int XW = 8,
    parameter int YW = 8,
    localparam int W = XW + YW + 2
) (
    input  logic [XW-1:0] mcand,
    input  logic [YW-1:0] mplier,
    output logic [W-1:0]  init_word,
    output logic [W-1:0]  plus_word,
    output logic [W-1:0]  minus_word
);
    localparam logic [XW:0] ONE = 1;

    logic [XW:0] mc_ext;
    logic [XW:0] mc_neg;

    // Sign-extend the multiplicand by one bit and form its negation.
    always_comb begin
        mc_ext = {mcand[XW-1], mcand};
        mc_neg = (~mc_ext) + ONE;
    end

    // Place the fields: multiplier in the middle, addends at the top.
    always_comb begin
        init_word  = {{(XW+1){1'b0}}, mplier, 1'b0};
        plus_word  = {mc_ext, {(YW+1){1'b0}}};
        minus_word = {mc_neg, {(YW+1){1'b0}}};
    end
endmodule

// File: rtl/booth_step.sv
// Module: booth_step
// One radix-2 Booth iteration: a conditional add of an addend word, then an
// arithmetic right shift by one. Carry out of the top bit is dropped.
// Combinational.
module booth_step #(
    parameter int W = 18
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] plus_word,
    input  logic [W-1:0] minus_word,
    output logic [W-1:0] nxt
);
    import booth_pkg::*;

    booth_act_e  act;
    logic [W-1:0] sum;

    // Decide the action and perform the modular add.
    always_comb begin
        act = pick_action(cur[1:0]);
        unique case (act)
            ACT_PLUS:  sum = cur + plus_word;
            ACT_MINUS: sum = cur + minus_word;
            default:   sum = cur;
        endcase
    end

    // Arithmetic shift right, copying the sign bit.
    always_comb begin
        nxt = {sum[W-1], sum[W-1:1]};
    end
endmodule

// File: rtl/booth_seq_ctrl.sv
// Module: booth_seq_ctrl
// Sequencer that accepts start only while idle, runs exactly YW steps and
// pulses done once. Assumes YW >= 1. Synchronous active-low reset.
module booth_seq_ctrl #(
    parameter int YW = 8,
    localparam int CW = $clog2(YW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic busy,
    output logic done
);
    localparam logic [CW-1:0] LAST = CW'(YW - 1);

    logic [CW-1:0] step_cnt;

    // Accept a new job only when no steps are pending.
    always_comb begin
        load = start & ~busy;
    end

    // Step counter, busy flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            step_cnt <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy     <= 1'b1;
                step_cnt <= '0;
            end else if (busy) begin
                if (step_cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    step_cnt <= step_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/booth_r2_seq_mult.sv
// Module: booth_r2_seq_mult
// Sequential radix-2 Booth multiplier for signed operands. The operands are
// captured on an accepted start. One step runs per clock for YW clocks, then
// the product is held. Synchronous active-low reset.
module booth_r2_seq_mult #(
    parameter int XW = 8,
    parameter int YW = 8,
    localparam int W  = XW + YW + 2,
    localparam int PW = XW + YW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [XW-1:0] mcand,
    input  logic [YW-1:0] mplier,
    output logic          busy,
    output logic          done,
    output logic [PW-1:0] product
);
    logic          load;
    logic [W-1:0]  init_word;
    logic [W-1:0]  plus_in;
    logic [W-1:0]  minus_in;
    logic [W-1:0]  plus_q;
    logic [W-1:0]  minus_q;
    logic [W-1:0]  work_q;
    logic [W-1:0]  work_nxt;

    booth_operand_prep #(.XW(XW), .YW(YW)) u_prep (
        .mcand      (mcand),
        .mplier     (mplier),
        .init_word  (init_word),
        .plus_word  (plus_in),
        .minus_word (minus_in)
    );

    booth_step #(.W(W)) u_step (
        .cur        (work_q),
        .plus_word  (plus_q),
        .minus_word (minus_q),
        .nxt        (work_nxt)
    );

    booth_seq_ctrl #(.YW(YW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .busy  (busy),
        .done  (done)
    );

    // Capture the addend words on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plus_q  <= '0;
            minus_q <= '0;
        end else if (load) begin
            plus_q  <= plus_in;
            minus_q <= minus_in;
        end
    end

    // Working register: load, step while busy, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
        end else if (load) begin
            work_q <= init_word;
        end else if (busy) begin
            work_q <= work_nxt;
        end
    end

    // Product is the register with its guard bit and top extension removed.
    always_comb begin
        product = work_q[PW:1];
    end
endmodule

// File: rtl/booth_r2_seq_mult_chk.sv
// Module: booth_r2_seq_mult_chk
// Port-level checker for the sequential Booth multiplier, bound to the top.
// Counts busy cycles locally so that the run length needs no deep $past.
module booth_r2_seq_mult_chk #(
    parameter int XW = 8,
    parameter int YW = 8,
    localparam int PW = XW + YW,
    localparam int CW = $clog2(YW + 2) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [PW-1:0] product
);
    logic [CW-1:0] busy_len;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_len == CW'(YW)));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

    // R7
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_len < CW'(YW)));
endmodule

bind booth_r2_seq_mult booth_r2_seq_mult_chk #(.XW(XW), .YW(YW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_r2_seq_mult_bench.sv
`timescale 1ns/1ps
module booth_r2_seq_mult_bench;
    localparam int XW = 5;
    localparam int YW = 4;
    localparam int PW = XW + YW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [XW-1:0] mcand = '0;
    logic [YW-1:0] mplier = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;
    logic [PW-1:0] held;

    booth_r2_seq_mult #(.XW(XW), .YW(YW)) u_booth_r2_seq_mult (
        .clk (clk), .rst_n (rst_n), .start (start),
        .mcand (mcand), .mplier (mplier),
        .busy (busy), .done (done), .product (product)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int expect_prod(input logic [XW-1:0] a, input logic [YW-1:0] b);
        int sa;
        int sb;
        sa = int'($signed(a));
        sb = int'($signed(b));
        return sa * sb;
    endfunction

    // Wait for done while counting samples; optionally poke start mid-run.
    task automatic wait_done(input logic [XW-1:0] a, input bit poke, output int k);
        k = 1;
        while (done !== 1'b1 && k <= YW + 4) begin
            if (poke && k == 2) begin
                start = 1'b1;
                mcand = a ^ 1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
    endtask

    // One isolated multiplication with latching, timing, value and hold checks.
    task automatic run_one(input logic [XW-1:0] a, input logic [YW-1:0] b, input bit poke);
        int k;
        int exp;
        exp = expect_prod(a, b);
        @(negedge clk);
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0; mcand = ~a; mplier = ~b;
        check(busy === 1'b1, "R2 busy after start", busy, 1);
        wait_done(a, poke, k);
        check(k == YW + 1, poke ? "R7 run length with start while busy" : "R3 done timing", k, YW + 1);
        check(int'($signed(product)) == exp, poke ? "R7 product with start while busy" : "R5 product",
              int'($signed(product)), exp);
        held = product;
        @(negedge clk);
        check(done === 1'b0, "R4 done single cycle", done, 0);
        check(product === held, "R6 product held", product, held);
        repeat (2) @(negedge clk);
        check(product === held, "R6 product held while idle", product, held);
    endtask

    // Back-to-back runs: start is raised in the cycle done is seen.
    task automatic run_chain(input int n);
        logic [XW-1:0] a;
        logic [YW-1:0] b;
        int k;
        @(negedge clk);
        a = XW'($urandom); b = YW'($urandom);
        mcand = a; mplier = b; start = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
            check(busy === 1'b1, "R8 busy after back-to-back start", busy, 1);
            check(done === 1'b0, "R4 done low after restart", done, 0);
            wait_done(a, 1'b0, k);
            check(k == YW + 1, "R8 back-to-back run length", k, YW + 1);
            check(int'($signed(product)) == expect_prod(a, b), "R8 back-to-back product",
                  int'($signed(product)), expect_prod(a, b));
            a = XW'($urandom); b = YW'($urandom);
            mcand = a; mplier = b; start = (i < n - 1);
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0, "R1 busy at reset", busy, 0);
        check(done === 1'b0, "R1 done at reset", done, 0);
        check(product === '0, "R1 product at reset", product, 0);

        // R9: recoding example 3 x -4 -> -12
        run_one(5'd3, 4'b1100, 1'b0);
        check(product === 9'h1F4, "R9 three times minus four", product, 9'h1F4);

        // R5: corners including most negative and all-ones operands.
        run_one(5'b10000, 4'b1000, 1'b0);
        run_one(5'b10000, 4'b0111, 1'b0);
        run_one(5'b11111, 4'b1111, 1'b0);
        run_one(5'b01111, 4'b1000, 1'b0);
        run_one(5'd0, 4'b1000, 1'b0);
        run_one(5'd1, 4'b1111, 1'b0);

        // R5: exhaustive sweep of every operand pair.
        for (int ia = 0; ia < (1 << XW); ia++) begin
            for (int ib = 0; ib < (1 << YW); ib++) begin
                run_one(XW'(ia), YW'(ib), 1'b0);
            end
        end

        // R7: start pulses while busy must be ignored.
        for (int i = 0; i < 40; i++) begin
            run_one(XW'($urandom), YW'($urandom), 1'b1);
        end

        // R8: back-to-back runs.
        run_chain(24);

        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end
endmodule